// File: doc/BRIEF.md
# Four-Function ALU With Stored Condition Codes

This block is the integer execute stage of a small processor. A 4-bit function code picks one of four operations on two word-wide operands: add, subtract, bitwise AND and bitwise XOR. Operand B is the destination register's value and operand A is the source register's value, so subtraction gives B minus A. The combinational result comes with three live flags: zero, sign and signed overflow.

A clocked condition-code register keeps those flags. It loads only on a clock edge where the load enable is high, so the caller raises it for arithmetic and logic instructions and for nothing else. From the stored flags the block also works out whether a branch is taken, for the always-taken jump and the six signed comparisons. There is no multiply, divide or shift.

Top module: `alu_cc_unit`

## Requirements
- R1: With function code 0 the result is (B + A) modulo 2^WIDTH.
- R2: With function code 1 the result is (B − A) modulo 2^WIDTH. The source operand A is taken away from the destination operand B.
- R3: With function code 2 the result is B AND A. With function code 3 it is B XOR A.
- R4: Function codes 4 to 15 give a result of zero. The live flags are then zero=1, sign=0, overflow=0.
- R5: The live zero flag is 1 exactly when the result is all zeros. The live sign flag equals the result's top bit.
- R6: For addition the live overflow flag is 1 exactly when the true signed sum B + A does not fit in WIDTH signed bits.
- R7: For subtraction the live overflow flag is 1 exactly when the true signed difference B − A does not fit in WIDTH signed bits. For AND and XOR it is 0.
- R8: On a rising clock edge with `cc_load` high, the stored flags take the live flag values. With `cc_load` low they keep their value.
- R9: While reset is asserted (active-low, asynchronous), the stored flags are zero=1, sign=0, overflow=0.
- R10: `take_jump` follows `jump_code` as follows. 0: always 1. 1: (sign XOR overflow) OR zero. 2: sign XOR overflow. 3: zero. 4: NOT zero. 5: NOT (sign XOR overflow). 6: NOT (sign XOR overflow) AND NOT zero.
- R11: Jump codes 7 to 15 give `take_jump` = 0.
- R12: `take_jump` and the stored-flag outputs use the flags held before the current edge. A load in the same cycle affects them only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_code | input | 4 | ALU function select (0 add, 1 sub, 2 and, 3 xor) |
| opnd_a | input | WIDTH | Source operand A |
| opnd_b | input | WIDTH | Destination operand B |
| cc_load | input | 1 | Load enable for the condition-code register |
| jump_code | input | 4 | Branch condition select (0 to 6 valid) |
| alu_out | output | WIDTH | Combinational result |
| live_zf | output | 1 | Zero flag of the current result |
| live_sf | output | 1 | Sign flag of the current result |
| live_of | output | 1 | Overflow flag of the current result |
| cc_zf | output | 1 | Stored zero flag |
| cc_sf | output | 1 | Stored sign flag |
| cc_of | output | 1 | Stored overflow flag |
| take_jump | output | 1 | Branch decision from the stored flags |

## Verification
A flag load and a branch evaluation can fall in the same cycle: an arithmetic instruction raises `cc_load` while `jump_code` asks about the flags. The bench provokes this in directed cases and on most random cycles. In those cycles the live flags differ from the stored ones, and the branch decision must still come from the old stored flags. It is judged against a reference model that updates its flag copy only after the edge, so any decision taken from the new flags shows up as a mismatch that cycle.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    JC_ALWAYS = 4'd0,
    JC_LE     = 4'd1,
    JC_LT     = 4'd2,
    JC_EQ     = 4'd3,
    JC_NE     = 4'd4,
    JC_GE     = 4'd5,
    JC_GT     = 4'd6
  } jump_cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_flags_t;

  localparam cc_flags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       fn_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output cc_flags_t        flags
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] dif_w;
  logic             add_ovf;
  logic             sub_ovf;

  // Destination operand is B; subtraction removes A from B.
  assign sum_w = opnd_b + opnd_a;
  assign dif_w = opnd_b - opnd_a;

  // Signed overflow from operand and result sign bits.
  assign add_ovf = (opnd_a[MSB] == opnd_b[MSB]) && (sum_w[MSB] != opnd_b[MSB]);
  assign sub_ovf = (opnd_a[MSB] != opnd_b[MSB]) && (dif_w[MSB] != opnd_b[MSB]);

  always_comb begin
    result   = '0;
    flags.of = 1'b0;
    case (fn_code)
      FN_ADD: begin
        result   = sum_w;
        flags.of = add_ovf;
      end
      FN_SUB: begin
        result   = dif_w;
        flags.of = sub_ovf;
      end
      FN_AND:  result = opnd_b & opnd_a;
      FN_XOR:  result = opnd_b ^ opnd_a;
      default: result = '0;
    endcase
    flags.zf = (result == '0);
    flags.sf = result[MSB];
  end

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
  import alu_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  cc_flags_t d,
  output cc_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= CC_RESET;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/alu_cc_cond.sv
module alu_cc_cond
  import alu_cc_pkg::*;
(
  input  cc_flags_t  cc,
  input  logic [3:0] jump_code,
  output logic       take
);
  logic below;

  assign below = cc.sf ^ cc.of;

  always_comb begin
    case (jump_code)
      JC_ALWAYS: take = 1'b1;
      JC_LE:     take = below | cc.zf;
      JC_LT:     take = below;
      JC_EQ:     take = cc.zf;
      JC_NE:     take = ~cc.zf;
      JC_GE:     take = ~below;
      JC_GT:     take = ~below & ~cc.zf;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       fn_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             cc_load,
  input  logic [3:0]       jump_code,
  output logic [WIDTH-1:0] alu_out,
  output logic             live_zf,
  output logic             live_sf,
  output logic             live_of,
  output logic             cc_zf,
  output logic             cc_sf,
  output logic             cc_of,
  output logic             take_jump
);
  cc_flags_t live_flags;
  cc_flags_t held_flags;

  alu_cc_datapath #(.WIDTH(WIDTH)) u_dp (
    .fn_code (fn_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (alu_out),
    .flags   (live_flags)
  );

  alu_cc_flagreg u_cc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cc_load),
    .d     (live_flags),
    .q     (held_flags)
  );

  alu_cc_cond u_jc (
    .cc        (held_flags),
    .jump_code (jump_code),
    .take      (take_jump)
  );

  assign live_zf = live_flags.zf;
  assign live_sf = live_flags.sf;
  assign live_of = live_flags.of;
  assign cc_zf   = held_flags.zf;
  assign cc_sf   = held_flags.sf;
  assign cc_of   = held_flags.of;

endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       fn_code,
  input logic             cc_load,
  input logic [3:0]       jump_code,
  input logic [WIDTH-1:0] alu_out,
  input logic             live_zf,
  input logic             live_sf,
  input logic             live_of,
  input logic             cc_zf,
  input logic             cc_sf,
  input logic             cc_of,
  input logic             take_jump
);
  // R4: unused function codes give a zero result
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_code > 4'd3) |-> (alu_out == '0));

  // R7: logic operations never raise overflow
  assert_logic_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fn_code == 4'd2) || (fn_code == 4'd3)) |-> !live_of);

  // R8: flags captured on a load edge
  assert_cc_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load |=> ({cc_zf, cc_sf, cc_of} == $past({live_zf, live_sf, live_of})));

  // R8: flags held without a load
  assert_cc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_load |=> $stable({cc_zf, cc_sf, cc_of}));

  // R9: reset value of the stored flags
  assert_cc_reset_R9: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (cc_zf && !cc_sf && !cc_of)));

  // R10: unconditional jump always taken
  assert_jump_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_code == 4'd0) |-> take_jump);

  // R11: unused jump codes never taken
  assert_jump_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_code > 4'd6) |-> !take_jump);

endmodule

bind alu_cc_unit alu_cc_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fn_code   (fn_code),
  .cc_load   (cc_load),
  .jump_code (jump_code),
  .alu_out   (alu_out),
  .live_zf   (live_zf),
  .live_sf   (live_sf),
  .live_of   (live_of),
  .cc_zf     (cc_zf),
  .cc_sf     (cc_sf),
  .cc_of     (cc_of),
  .take_jump (take_jump)
);

// File: tb/alu_cc_unit_tb_top.sv
`timescale 1ns/1ps
module alu_cc_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   fn_code = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         cc_load = 1'b0;
  logic [3:0]   jump_code = '0;
  logic [W-1:0] alu_out;
  logic         live_zf, live_sf, live_of;
  logic         cc_zf, cc_sf, cc_of;
  logic         take_jump;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference copy of the stored flags
  bit m_zf = 1, m_sf = 0, m_of = 0;

  always #4 clk = ~clk;

  alu_cc_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fn_code(fn_code), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .cc_load(cc_load), .jump_code(jump_code),
    .alu_out(alu_out), .live_zf(live_zf), .live_sf(live_sf),
    .live_of(live_of), .cc_zf(cc_zf), .cc_sf(cc_sf), .cc_of(cc_of),
    .take_jump(take_jump)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit jump_model(input int jc, input bit z, input bit s, input bit o);
    bit lt = s ^ o;
    case (jc)
      0: return 1;
      1: return lt || z;
      2: return lt;
      3: return z;
      4: return !z;
      5: return !lt;
      6: return !lt && !z;
      default: return 0;
    endcase
  endfunction

  task automatic step(input int fn, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit ld, input int jc);
    longint sa, sb, wide;
    logic [W-1:0] exp_r;
    bit exp_of, exp_j;
    string tag;
    @(negedge clk);
    fn_code = fn[3:0]; opnd_a = a; opnd_b = b; cc_load = ld; jump_code = jc[3:0];
    #1;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    exp_of = 0;
    case (fn)
      0: begin wide = sb + sa; exp_r = b + a; exp_of = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); tag = "R1/R6"; end
      1: begin wide = sb - sa; exp_r = b - a; exp_of = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); tag = "R2/R7"; end
      2: begin exp_r = b & a; tag = "R3/R7"; end
      3: begin exp_r = b ^ a; tag = "R3/R7"; end
      default: begin exp_r = '0; tag = "R4"; end
    endcase
    check(alu_out === exp_r, {tag, " result"}, longint'(alu_out), longint'(exp_r));
    check(live_of === exp_of, {tag, " overflow"}, longint'(live_of), longint'(exp_of));
    check(live_zf === (exp_r == 0), "R5 zero", longint'(live_zf), longint'(exp_r == 0));
    check(live_sf === exp_r[W-1], "R5 sign", longint'(live_sf), longint'(exp_r[W-1]));
    // R12: stored flags and the decision reflect the pre-edge state
    check({cc_zf, cc_sf, cc_of} === {m_zf, m_sf, m_of}, "R8/R12 stored flags",
          longint'({cc_zf, cc_sf, cc_of}), longint'({m_zf, m_sf, m_of}));
    exp_j = jump_model(jc, m_zf, m_sf, m_of);
    check(take_jump === exp_j, (jc > 6) ? "R11 jump" : "R10/R12 jump",
          longint'(take_jump), longint'(exp_j));
    @(posedge clk);
    if (ld) begin
      m_zf = (exp_r == 0); m_sf = exp_r[W-1]; m_of = exp_of;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({cc_zf, cc_sf, cc_of} === 3'b100, "R9 reset flags", longint'({cc_zf, cc_sf, cc_of}), 64'h4);
    rst_n = 1'b1;
    // R1 / R6 addition cases
    step(0, 32'd1, 32'd1, 1, 3);
    step(0, 32'd1, 32'h7fffffff, 1, 3);
    step(0, 32'h80000000, 32'h80000000, 1, 2);
    step(0, 32'hffffffff, 32'd1, 1, 1);
    // R2 / R7 subtraction, B minus A
    step(1, 32'd3, 32'd5, 1, 6);
    step(1, 32'd1, 32'h80000000, 1, 6);
    step(1, 32'hffffffff, 32'h7fffffff, 1, 5);
    step(1, 32'd9, 32'd9, 1, 4);
    // R3 logic
    step(2, 32'hf0f0f0f0, 32'hff00ff00, 1, 3);
    step(3, 32'h12345678, 32'h12345678, 1, 4);
    // R4 unused function codes, R8 hold without load
    step(7, 32'hdeadbeef, 32'h1, 0, 3);
    step(15, 32'h5, 32'h5, 1, 0);
    step(0, 32'h80000000, 32'd0, 0, 2);
    step(0, 32'h80000000, 32'd0, 0, 2);
    // R10 / R11 all jump codes over several stored states
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: step(1, 32'd2, 32'd1, 1, 0);
        1: step(1, 32'd1, 32'd2, 1, 0);
        2: step(1, 32'd4, 32'd4, 1, 0);
        default: step(0, 32'h7fffffff, 32'h7fffffff, 1, 0);
      endcase
      for (int j = 0; j < 16; j++) step(2, 32'd0, 32'd0, 0, j);
    end
    // random cycles with concurrent load and branch evaluation
    for (int k = 0; k < 400; k++) begin
      step(int'($urandom_range(0, 5)), $urandom, $urandom,
           bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 8)));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule